// File: doc/BRIEF.md
# SD Host Simple-DMA Boundary Engine

This block moves block data for an SD host controller without descriptors. Software loads a system address, picks a direction, a block size, a block count and a boundary size, then pulses a start. For a card read the engine collects one whole block from the card byte stream into a local buffer and then writes it byte by byte to memory. For a card write it gathers a whole block from memory and then streams it to the card. The system address advances by one for every byte moved on the memory port.

In multi-block transfers whose start address is aligned to the selected boundary, the engine halts as soon as the address reaches the next boundary while blocks remain. It raises a one-cycle DMA interrupt pulse, if enabled, and keeps the byte index inside the current block. Software then writes the most significant byte of the address register, with a new or the same value, and the engine resumes mid-block where it stopped. At the end it pulses transfer-complete and returns to idle.

The card side uses two byte streams with valid/ready. A byte moves on a cycle where both are high, and the sender keeps its byte stable while ready is low. The memory side is a request/ready byte port. The engine holds its request, write flag, address and write data until ready, and a read takes `mem_rdata_i` on the ready cycle. The configuration inputs are sampled only at start.

Top module: `sd_sdma_engine`

## Requirements
- R1: A start pulse is taken only when idle. It is ignored, with no bus or card activity and no completion pulse, if the block size is 0 or above MAX_BLK, or if multi-block mode is chosen with block counting disabled or a count of 0.
- R2: The boundary size is 2^(sel+BND_BASE) bytes, where sel is the 3-bit `bnd_sel_i` and BND_BASE is 12 by default (4 KiB to 512 KiB). The bytes left to the boundary are that size minus the address modulo that size.
- R3: In a multi-block transfer of more than one block with a boundary-aligned start, the engine halts after the byte that reaches the boundary if blocks remain. `paused_o` rises and `dma_int_o` pulses once, only when `dma_int_en_i` is 1, and the byte index within the block is kept.
- R4: A start address that is not aligned to the boundary runs to the end with no halt.
- R5: Each accepted memory beat uses the current system address and then adds 1 to it, so the final address is the start plus the bytes moved.
- R6: The block count drops by one per completed block, only when counting is enabled. When a multi-block count reaches 0 the engine stops, pulses `done_o` for one cycle and drops `busy_o`.
- R7: Single-block mode, or a count of 1, moves exactly one block with no boundary halt. The count is decremented only when counting is enabled and it is nonzero.
- R8: On a card read, all block-size bytes of a block are taken from the card before the first memory write of that block, and memory receives the card bytes in order.
- R9: On a card write, all bytes of a block are read from memory before the first card byte of that block, and the card receives them in address order.
- R10: While halted, an address write that enables the top byte resumes the transfer. The boundary is recomputed from the address at that moment, and a mid-block halt continues with no second card fetch. An address write without the top byte enabled does not resume.
- R11: The address register takes byte-enabled writes only while idle or halted. Writes during an active transfer are ignored.
- R12: A pending memory request keeps its address and direction until `mem_ready_i`, and a pending card byte keeps its data until `card_tx_ready_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| dir_read_i | input | 1 | 1: card to memory, 0: memory to card |
| multi_i | input | 1 | Multi-block mode |
| cnt_en_i | input | 1 | Block counting enable |
| blk_size_i | input | BLK_W | Bytes per block, 1..MAX_BLK |
| bnd_sel_i | input | 3 | Boundary size select |
| blk_cnt_i | input | CNT_W | Block count loaded at start |
| dma_int_en_i | input | 1 | Enable for the boundary interrupt pulse |
| addr_wr_i | input | 1 | Address register write strobe |
| addr_be_i | input | ADDR_W/8 | Byte enables of the address write |
| addr_wdata_i | input | ADDR_W | Address write data |
| sys_addr_o | output | ADDR_W | Current system address |
| blk_cnt_o | output | CNT_W | Remaining block count |
| busy_o | output | 1 | Transfer in progress, including halted |
| paused_o | output | 1 | Halted at a boundary |
| dma_int_o | output | 1 | Boundary interrupt pulse |
| done_o | output | 1 | Transfer-complete pulse |
| card_rx_valid_i | input | 1 | Card byte valid (read path) |
| card_rx_data_i | input | 8 | Card byte (read path) |
| card_rx_ready_o | output | 1 | Engine accepts a card byte |
| card_tx_valid_o | output | 1 | Engine offers a card byte (write path) |
| card_tx_data_o | output | 8 | Byte to the card |
| card_tx_ready_i | input | 1 | Card accepts the byte |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1: memory write, 0: memory read |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_ready_i | input | 1 | Memory completes the beat |
| mem_rdata_i | input | 8 | Memory read data, valid with ready |

## Verification
A wrong boundary remainder or a lost alignment flag shows at the ports as a halt at the wrong address or a missing halt. This appears on the first boundary crossing, within one block of the expected point. A byte index that is dropped at a halt shows as a second card fetch or shifted data at the first beat after resume. A bad count update shows as a late or early `done_o` and a nonzero `blk_cnt_o` at the end. Store-and-forward slips show as a memory write made before a whole block was taken from the card, or as a card byte sent before the whole block was read from memory, within one block.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  localparam int SDMA_SEL_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_FILL,
    ST_PUSH,
    ST_PULL,
    ST_SEND,
    ST_HALT
  } sdma_state_e;

  typedef struct packed {
    logic                  rd;
    logic                  multi;
    logic                  cnt_en;
    logic                  single;
    logic [SDMA_SEL_W-1:0] sel;
  } sdma_cfg_t;

endpackage

// File: rtl/sdma_boundary_calc.sv
module sdma_boundary_calc #(
  parameter int BND_BASE = 12,
  parameter int SEL_W    = 3,
  localparam int BND_W   = BND_BASE + (1 << SEL_W)
) (
  input  logic [BND_W-1:0] addr_lo_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [BND_W-1:0] left_o,
  output logic             aligned_o
);
  logic [BND_W-1:0] span;
  logic [BND_W-1:0] offs;

  always_comb begin
    span      = {{(BND_W-1){1'b0}}, 1'b1} << (32'(sel_i) + BND_BASE);
    offs      = addr_lo_i & (span - {{(BND_W-1){1'b0}}, 1'b1});
    aligned_o = (offs == '0);
    left_o    = span - offs;
  end
endmodule

// File: rtl/sdma_block_buffer.sv
module sdma_block_buffer #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/sdma_addr_reg.sv
module sdma_addr_reg #(
  parameter int ADDR_W = 32,
  localparam int NB    = ADDR_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [NB-1:0]     be_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] q_o
);
  logic [ADDR_W-1:0] stepped;

  assign stepped = adv_i ? q_o + {{(ADDR_W-1){1'b0}}, 1'b1} : q_o;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              q_o[b*8 +: 8] <= '0;
      else if (wr_i && be_i[b]) q_o[b*8 +: 8] <= wdata_i[b*8 +: 8];
      else                     q_o[b*8 +: 8] <= stepped[b*8 +: 8];
    end
  end
endmodule

// File: rtl/sd_sdma_engine.sv
module sd_sdma_engine
  import sdma_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_BLK  = 64,
  parameter int CNT_W    = 16,
  parameter int BND_BASE = 12,
  localparam int BLK_W   = $clog2(MAX_BLK + 1),
  localparam int NBYTES  = ADDR_W / 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  dir_read_i,
  input  logic                  multi_i,
  input  logic                  cnt_en_i,
  input  logic [BLK_W-1:0]      blk_size_i,
  input  logic [SDMA_SEL_W-1:0] bnd_sel_i,
  input  logic [CNT_W-1:0]      blk_cnt_i,
  input  logic                  dma_int_en_i,
  input  logic                  addr_wr_i,
  input  logic [NBYTES-1:0]     addr_be_i,
  input  logic [ADDR_W-1:0]     addr_wdata_i,
  output logic [ADDR_W-1:0]     sys_addr_o,
  output logic [CNT_W-1:0]      blk_cnt_o,
  output logic                  busy_o,
  output logic                  paused_o,
  output logic                  dma_int_o,
  output logic                  done_o,
  input  logic                  card_rx_valid_i,
  input  logic [7:0]            card_rx_data_i,
  output logic                  card_rx_ready_o,
  output logic                  card_tx_valid_o,
  output logic [7:0]            card_tx_data_o,
  input  logic                  card_tx_ready_i,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [7:0]            mem_wdata_o,
  input  logic                  mem_ready_i,
  input  logic [7:0]            mem_rdata_i
);
  localparam int BUF_AW = $clog2(MAX_BLK);
  localparam int BND_W  = BND_BASE + (1 << SDMA_SEL_W);

  sdma_state_e      state_q;
  sdma_cfg_t        cfg_q;
  logic [BLK_W-1:0] bsz_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BLK_W-1:0] idx_q;     // memory-side byte index in block
  logic [BLK_W-1:0] cidx_q;    // card-side byte index in block
  logic [BND_W-1:0] bleft_q;   // bytes before the boundary
  logic             use_bnd_q;
  logic             bnd_hit_q;
  logic             dma_int_q;
  logic             done_q;

  // ---------------------------------------------------------------
  // Boundary arithmetic on the live address (R2)
  // ---------------------------------------------------------------
  logic [BND_W-1:0] bnd_left;
  logic             bnd_aligned;
  logic [ADDR_W-1:0] cur_addr;

  sdma_boundary_calc #(.BND_BASE(BND_BASE), .SEL_W(SDMA_SEL_W)) u_bnd (
    .addr_lo_i (cur_addr[BND_W-1:0]),
    .sel_i     (cfg_q.sel),
    .left_o    (bnd_left),
    .aligned_o (bnd_aligned)
  );

  // ---------------------------------------------------------------
  // Handshake qualifiers
  // ---------------------------------------------------------------
  logic in_fill, in_push, in_pull, in_send, in_halt, in_idle;
  assign in_idle = (state_q == ST_IDLE);
  assign in_fill = (state_q == ST_FILL);
  assign in_push = (state_q == ST_PUSH);
  assign in_pull = (state_q == ST_PULL);
  assign in_send = (state_q == ST_SEND);
  assign in_halt = (state_q == ST_HALT);

  logic rx_fire, tx_fire, mem_fire;
  assign rx_fire  = in_fill && card_rx_valid_i;
  assign tx_fire  = in_send && card_tx_ready_i;
  assign mem_fire = (in_push || in_pull) && mem_ready_i;

  // ---------------------------------------------------------------
  // Address register (R5, R11)
  // ---------------------------------------------------------------
  logic addr_wr_ok;
  assign addr_wr_ok = addr_wr_i && (in_idle || in_halt);

  sdma_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (addr_wr_ok),
    .be_i    (addr_be_i),
    .wdata_i (addr_wdata_i),
    .adv_i   (mem_fire),
    .q_o     (cur_addr)
  );

  // ---------------------------------------------------------------
  // Block buffer (R8, R9)
  // ---------------------------------------------------------------
  logic              buf_we;
  logic [BUF_AW-1:0] buf_waddr, buf_raddr;
  logic [7:0]        buf_wdata, buf_rdata;

  assign buf_we    = rx_fire || (in_pull && mem_ready_i);
  assign buf_waddr = in_fill ? cidx_q[BUF_AW-1:0] : idx_q[BUF_AW-1:0];
  assign buf_wdata = in_fill ? card_rx_data_i : mem_rdata_i;
  assign buf_raddr = in_send ? cidx_q[BUF_AW-1:0] : idx_q[BUF_AW-1:0];

  sdma_block_buffer #(.DEPTH(MAX_BLK)) u_buf (
    .clk     (clk),
    .we_i    (buf_we),
    .waddr_i (buf_waddr),
    .wdata_i (buf_wdata),
    .raddr_i (buf_raddr),
    .rdata_o (buf_rdata)
  );

  // ---------------------------------------------------------------
  // Decisions
  // ---------------------------------------------------------------
  logic             size_ok, start_ok, restart;
  logic             mem_last, card_last, bnd_reach, finish;
  logic [CNT_W-1:0] cnt_next;

  assign size_ok  = (blk_size_i != '0) && (blk_size_i <= BLK_W'(MAX_BLK));
  assign start_ok = start_i && in_idle && size_ok &&
                    !(multi_i && (!cnt_en_i || blk_cnt_i == '0));
  assign restart  = in_halt && addr_wr_i && addr_be_i[NBYTES-1];

  assign mem_last  = (idx_q  == bsz_q - BLK_W'(1));
  assign card_last = (cidx_q == bsz_q - BLK_W'(1));
  assign bnd_reach = use_bnd_q && (bleft_q == BND_W'(1));
  assign cnt_next  = (cfg_q.cnt_en && cnt_q != '0) ? cnt_q - CNT_W'(1) : cnt_q;
  assign finish    = cfg_q.single || (cnt_next == '0);

  // ---------------------------------------------------------------
  // Control sequence
  // ---------------------------------------------------------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cfg_q     <= '0;
      bsz_q     <= '0;
      cnt_q     <= '0;
      idx_q     <= '0;
      cidx_q    <= '0;
      bleft_q   <= '0;
      use_bnd_q <= 1'b0;
      bnd_hit_q <= 1'b0;
      dma_int_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      dma_int_q <= 1'b0;
      done_q    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            cfg_q.rd     <= dir_read_i;
            cfg_q.multi  <= multi_i;
            cfg_q.cnt_en <= cnt_en_i;
            cfg_q.single <= !multi_i || (blk_cnt_i == CNT_W'(1));
            cfg_q.sel    <= bnd_sel_i;
            bsz_q        <= blk_size_i;
            cnt_q        <= blk_cnt_i;
            idx_q        <= '0;
            cidx_q       <= '0;
            state_q      <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          use_bnd_q <= !cfg_q.single && bnd_aligned;
          bleft_q   <= bnd_left;
          bnd_hit_q <= 1'b0;
          if (!cfg_q.rd)            state_q <= ST_PULL;
          else if (idx_q == '0)     state_q <= ST_FILL;
          else                      state_q <= ST_PUSH;
        end
        ST_FILL: begin
          if (rx_fire) begin
            if (card_last) begin
              cidx_q  <= '0;
              state_q <= ST_PUSH;
            end else begin
              cidx_q <= cidx_q + BLK_W'(1);
            end
          end
        end
        ST_PUSH: begin
          if (mem_ready_i) begin
            bleft_q <= bleft_q - BND_W'(1);
            if (mem_last) begin
              idx_q <= '0;
              cnt_q <= cnt_next;
              if (finish) begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end else if (bnd_reach) begin
                dma_int_q <= dma_int_en_i;
                state_q   <= ST_HALT;
              end else begin
                state_q <= ST_FILL;
              end
            end else begin
              idx_q <= idx_q + BLK_W'(1);
              if (bnd_reach) begin
                dma_int_q <= dma_int_en_i;
                state_q   <= ST_HALT;
              end
            end
          end
        end
        ST_PULL: begin
          if (mem_ready_i) begin
            bleft_q <= bleft_q - BND_W'(1);
            if (mem_last) begin
              idx_q     <= '0;
              bnd_hit_q <= bnd_reach;
              state_q   <= ST_SEND;
            end else begin
              idx_q <= idx_q + BLK_W'(1);
              if (bnd_reach) begin
                dma_int_q <= dma_int_en_i;
                state_q   <= ST_HALT;
              end
            end
          end
        end
        ST_SEND: begin
          if (tx_fire) begin
            if (card_last) begin
              cidx_q <= '0;
              cnt_q  <= cnt_next;
              if (finish) begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end else if (bnd_hit_q) begin
                dma_int_q <= dma_int_en_i;
                state_q   <= ST_HALT;
              end else begin
                state_q <= ST_PULL;
              end
            end else begin
              cidx_q <= cidx_q + BLK_W'(1);
            end
          end
        end
        ST_HALT: begin
          if (restart) state_q <= ST_LOAD;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // ---------------------------------------------------------------
  // Outputs
  // ---------------------------------------------------------------
  assign sys_addr_o      = cur_addr;
  assign blk_cnt_o       = cnt_q;
  assign busy_o          = !in_idle;
  assign paused_o        = in_halt;
  assign dma_int_o       = dma_int_q;
  assign done_o          = done_q;
  assign card_rx_ready_o = in_fill;
  assign card_tx_valid_o = in_send;
  assign card_tx_data_o  = buf_rdata;
  assign mem_req_o       = in_push || in_pull;
  assign mem_we_o        = in_push;
  assign mem_addr_o      = cur_addr;
  assign mem_wdata_o     = buf_rdata;

  // ---------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_ready_i |=> sys_addr_o == $past(sys_addr_o) + 1);

  a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  a_r12_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    card_tx_valid_o && !card_tx_ready_i |=> card_tx_valid_o && $stable(card_tx_data_o));

  a_r3_halt_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused_o) |-> bnd_aligned);

  a_r3_int_only_halted: assert property (@(posedge clk) disable iff (!rst_n)
    dma_int_o |-> paused_o);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o && !card_rx_ready_o && !card_tx_valid_o);

  a_r11_frozen_addr: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !paused_o && !mem_req_o && $past(busy_o) && !$past(paused_o) && !$past(mem_req_o)
    |-> $stable(sys_addr_o));
endmodule

// File: tb/test_sd_sdma_engine.sv
module test_sd_sdma_engine;
  localparam int ADDR_W = 32;
  localparam int MAXB   = 32;
  localparam int CNTW   = 8;
  localparam int BASE   = 4;
  localparam int BLKW   = $clog2(MAXB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              start_i = 0, dir_read_i = 0, multi_i = 0, cnt_en_i = 0, dma_int_en_i = 0;
  logic [BLKW-1:0]   blk_size_i = '0;
  logic [2:0]        bnd_sel_i = '0;
  logic [CNTW-1:0]   blk_cnt_i = '0;
  logic              addr_wr_i = 0;
  logic [3:0]        addr_be_i = '0;
  logic [31:0]       addr_wdata_i = '0;
  logic [31:0]       sys_addr_o, mem_addr_o;
  logic [CNTW-1:0]   blk_cnt_o;
  logic              busy_o, paused_o, dma_int_o, done_o;
  logic              card_rx_valid_i = 0, card_rx_ready_o, card_tx_valid_o, card_tx_ready_i = 0;
  logic [7:0]        card_rx_data_i = '0, card_tx_data_o, mem_wdata_o, mem_rdata_i = '0;
  logic              mem_req_o, mem_we_o, mem_ready_i = 0;

  sd_sdma_engine #(.ADDR_W(ADDR_W), .MAX_BLK(MAXB), .CNT_W(CNTW), .BND_BASE(BASE)) i_sd_sdma_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_read_i(dir_read_i), .multi_i(multi_i),
    .cnt_en_i(cnt_en_i), .blk_size_i(blk_size_i), .bnd_sel_i(bnd_sel_i), .blk_cnt_i(blk_cnt_i),
    .dma_int_en_i(dma_int_en_i), .addr_wr_i(addr_wr_i), .addr_be_i(addr_be_i),
    .addr_wdata_i(addr_wdata_i), .sys_addr_o(sys_addr_o), .blk_cnt_o(blk_cnt_o), .busy_o(busy_o),
    .paused_o(paused_o), .dma_int_o(dma_int_o), .done_o(done_o),
    .card_rx_valid_i(card_rx_valid_i), .card_rx_data_i(card_rx_data_i), .card_rx_ready_o(card_rx_ready_o),
    .card_tx_valid_o(card_tx_valid_o), .card_tx_data_o(card_tx_data_o), .card_tx_ready_i(card_tx_ready_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i));

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem [4096];
  logic [7:0] txlog [256];
  int phase = 0, rx_seq = 0, rx_cnt = 0, tx_cnt = 0, mem_beats = 0, req_cnt = 0;
  int done_cnt = 0, int_cnt = 0, order_bad = 0;
  int mem0 = 0, rx0 = 0, tx0 = 0, bs_cur = 1;

  function automatic logic [7:0] cb(int n);
    return 8'((n * 13 + 5) & 255);
  endfunction
  function automatic logic [7:0] mpat(int a);
    return 8'((a * 7 + 1 + a / 256) & 255);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // responders and monitors, all at the falling edge
  always @(negedge clk) begin
    phase++;
    mem_ready_i = mem_req_o && (phase % 3 != 0);
    if (mem_req_o) req_cnt++;
    if (mem_req_o && mem_ready_i) begin
      if (mem_we_o) begin
        if ((rx_cnt - rx0) < bs_cur * ((mem_beats - mem0) / bs_cur + 1)) order_bad++;
        mem[mem_addr_o[11:0]] = mem_wdata_o;
      end else begin
        mem_rdata_i = mem[mem_addr_o[11:0]];
      end
      mem_beats++;
    end
    card_rx_valid_i = (phase % 4 != 1);
    card_rx_data_i  = cb(rx_seq);
    if (card_rx_valid_i && card_rx_ready_o) begin
      rx_seq++;
      rx_cnt++;
    end
    card_tx_ready_i = (phase % 5 != 2);
    if (card_tx_valid_o && card_tx_ready_i) begin
      if ((mem_beats - mem0) < bs_cur * ((tx_cnt - tx0) / bs_cur + 1)) order_bad++;
      if (tx_cnt - tx0 < 256) txlog[tx_cnt - tx0] = card_tx_data_o;
      tx_cnt++;
    end
    if (done_o) done_cnt++;
    if (dma_int_o) int_cnt++;
  end

  task automatic addr_write(logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    addr_wr_i = 1; addr_be_i = be; addr_wdata_i = d;
    @(negedge clk);
    addr_wr_i = 0; addr_be_i = '0;
  endtask

  task automatic do_run(bit rd, bit multi, bit cen, int bs, int sel, int a, int cnt,
                        bit ien, bit poke, int newa);
    int big_b, total, single, exp_p, np, d0, i0, ob0, sq0, tmo, exp_cnt, exp_end;
    bit poked;
    big_b  = 1 << (sel + BASE);
    single = (!multi || cnt == 1) ? 1 : 0;
    total  = single ? bs : cnt * bs;
    exp_p  = (!single && (a % big_b == 0)) ? (total - 1) / big_b : 0;
    if (newa != 0) exp_p = 1;
    exp_end = (newa != 0) ? newa + total - big_b : a + total;
    exp_cnt = !cen ? cnt : (single ? (cnt == 0 ? 0 : cnt - 1) : 0);
    if (!rd) for (int k = 0; k < 4096; k++) mem[k] = mpat(k);
    addr_write(4'hF, 32'(a));
    @(negedge clk);
    mem0 = mem_beats; rx0 = rx_cnt; tx0 = tx_cnt; bs_cur = bs;
    d0 = done_cnt; i0 = int_cnt; ob0 = order_bad; sq0 = rx_seq;
    dir_read_i = rd; multi_i = multi; cnt_en_i = cen; blk_size_i = BLKW'(bs);
    bnd_sel_i = 3'(sel); blk_cnt_i = CNTW'(cnt); dma_int_en_i = ien;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    np = 0; poked = 0; tmo = 0;
    while (busy_o && tmo < 6000) begin
      if (paused_o) begin
        chk(sys_addr_o == 32'(a + (np + 1) * big_b), "R3", "halt address",
            int'(sys_addr_o), a + (np + 1) * big_b);
        np++;
        if (newa != 0) begin
          addr_write(4'h1, sys_addr_o);
          repeat (4) @(negedge clk);
          chk(paused_o == 1'b1, "R10", "low-byte write keeps halt", int'(paused_o), 1);
          addr_write(4'hF, 32'(newa));
        end else begin
          addr_write(4'h8, sys_addr_o);
        end
      end else begin
        if (poke && !poked && !paused_o && (mem_beats - mem0) >= 2) begin
          poked = 1;
          addr_write(4'hF, 32'h0000_0ABC);
        end else begin
          @(negedge clk);
        end
      end
      tmo++;
    end
    repeat (3) @(negedge clk);
    if (tmo >= 6000) chk(0, "R6", "run timeout", tmo, 0);
    chk(np == exp_p, exp_p ? "R3" : (single ? "R7" : "R4"), "halt count", np, exp_p);
    chk(int_cnt - i0 == (ien ? exp_p : 0), "R3", "dma interrupt pulses", int_cnt - i0, ien ? exp_p : 0);
    chk(sys_addr_o == 32'(exp_end), poke ? "R11" : "R5", "final address", int'(sys_addr_o), exp_end);
    chk(int'(blk_cnt_o) == exp_cnt, "R6", "final block count", int'(blk_cnt_o), exp_cnt);
    chk(done_cnt - d0 == 1, "R6", "completion pulses", done_cnt - d0, 1);
    chk(order_bad == ob0, rd ? "R8" : "R9", "store-and-forward order", order_bad - ob0, 0);
    if (rd) begin
      int bad;
      bad = -1;
      chk(rx_cnt - rx0 == total, newa != 0 ? "R10" : "R8", "card bytes taken", rx_cnt - rx0, total);
      for (int k = 0; k < total; k++) begin
        int ad;
        ad = (newa != 0 && k >= big_b) ? newa + k - big_b : a + k;
        if (bad < 0 && mem[ad % 4096] != cb(sq0 + k)) bad = k;
      end
      chk(bad < 0, "R8", "memory data (first bad index)", bad, -1);
    end else begin
      int bad;
      bad = -1;
      chk(tx_cnt - tx0 == total, "R9", "card bytes sent", tx_cnt - tx0, total);
      for (int k = 0; k < total && k < 256; k++) begin
        int ad;
        ad = (newa != 0 && k >= big_b) ? newa + k - big_b : a + k;
        if (bad < 0 && txlog[k] != mpat(ad)) bad = k;
      end
      chk(bad < 0, "R9", "card data (first bad index)", bad, -1);
    end
  endtask

  task automatic try_reject(bit multi, bit cen, int bs, int cnt);
    int r0, d0;
    @(negedge clk);
    r0 = req_cnt; d0 = done_cnt;
    dir_read_i = 1; multi_i = multi; cnt_en_i = cen; blk_size_i = BLKW'(bs);
    blk_cnt_i = CNTW'(cnt); start_i = 1;
    @(negedge clk);
    start_i = 0;
    repeat (10) @(negedge clk);
    chk(busy_o == 1'b0 && req_cnt == r0 && done_cnt == d0, "R1", "rejected start stays idle",
        int'(busy_o) + req_cnt - r0, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all-requirements: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy_o && !paused_o && !mem_req_o && sys_addr_o == 0 && blk_cnt_o == 0,
        "R1", "reset state", int'(busy_o) + int'(sys_addr_o), 0);

    // R11: byte-enabled writes while idle
    addr_write(4'hF, 32'h1234_5678);
    addr_write(4'h2, 32'h0000_AB00);
    @(negedge clk);
    chk(sys_addr_o == 32'h1234_AB78, "R11", "byte-enable merge", int'(sys_addr_o), 32'h1234_AB78);

    // R1: rejected starts
    try_reject(1, 0, 8, 4);
    try_reject(1, 1, 8, 0);
    try_reject(0, 1, 0, 1);
    try_reject(0, 1, MAXB + 1, 1);

    // R2..R9: sweep of direction, block size, boundary, alignment, count
    for (int rd = 0; rd < 2; rd++)
      for (int bi = 0; bi < 4; bi++)
        for (int sel = 0; sel < 2; sel++)
          for (int al = 0; al < 2; al++)
            for (int ci = 0; ci < 3; ci++) begin
              int bs, cnt;
              bs  = (bi == 0) ? 1 : (bi == 1) ? 3 : (bi == 2) ? 8 : 24;
              cnt = (ci == 0) ? 1 : (ci == 1) ? 2 : 5;
              do_run(rd[0], 1, 1, bs, sel, al ? 32'h100 : 32'h105, cnt, 1, 0, 0);
            end

    // R7: single-block mode, block larger than boundary, counted and uncounted
    do_run(1, 0, 1, 24, 0, 32'h200, 5, 1, 0, 0);
    do_run(0, 0, 0, 24, 0, 32'h200, 5, 1, 0, 0);
    // R3: interrupt disabled still halts
    do_run(1, 1, 1, 8, 0, 32'h300, 4, 0, 0, 0);
    // R11: address write during active transfer ignored
    do_run(1, 1, 1, 8, 1, 32'h305, 3, 1, 1, 0);
    do_run(0, 1, 1, 8, 1, 32'h305, 3, 1, 1, 0);
    // R10: mid-block halt, resume at a new aligned address
    do_run(1, 1, 1, 3, 0, 32'h210, 8, 1, 0, 32'h400);
    do_run(0, 1, 1, 3, 0, 32'h210, 8, 1, 0, 32'h400);

    summary();
    $finish;
  end
endmodule